// File: doc/BRIEF.md
# Interrupt Acknowledge Termination Controller

This block runs the acknowledge phase of an interrupt once priority arbitration has chosen a winner. A one-cycle start pulse tells it which side won. If an on-chip module won, the block waits for that module's acknowledge and passes on the vector the module supplies. If the external-request path won, the block forwards the cycle to the external bus by raising `ext_cycle`. It then accepts one of three answers from the bus: a vector with an acknowledge, an autovector request, or a chip-select hit that stands in for either of them.

A bus-monitor countdown guards every cycle. The limit is taken from `bm_limit` at start and clamped to between 8 and 64 clocks. If the monitor is enabled and nothing answers within that window, the cycle ends with a bus error, and the result is marked as a spurious interrupt. Each termination raises `done` for exactly one clock, with a kind code and a vector number. The block is back in idle on that same clock.

Top module: `iack_term_ctrl`

## Requirements
- R1: While reset is held and just after it is released, busy, ext_cycle, done, berr and spurious are 0, vector is 0 and term_kind is 0.
- R2: A start with win_internal=1 enters an internal wait with ext_cycle=0. The first clock edge that samples int_ack=1 ends the cycle. On the following clock done=1, term_kind=2'b00 and vector equals the int_vec sampled on that edge.
- R3: A start with win_internal=0 enters an external wait with ext_cycle=1. A sampled ext_ack ends the cycle with term_kind=2'b01 and vector equal to the sampled ext_vec.
- R4: In the external wait, a sampled ext_avec ends the cycle with term_kind=2'b10 and vector=24+level. Here level is the iack_level captured at start. When ext_avec and ext_ack are sampled on the same edge, the autovector result wins.
- R5: In the external wait, cs_hit=1 stands in for a bus answer. With cs_avec=1 it gives the R4 autovector result. With cs_avec=0 it gives the R3 acknowledge result using ext_vec.
- R6: During an internal wait, ext_ack, ext_avec and cs_hit have no effect. The cycle stays busy and ends only through int_ack or a timeout.
- R7: bm_limit is clamped to [8,64] and captured at start. With bm_enable=1 captured at start, the clamped limit L sets the response window. Answers are accepted on the L edges that follow the start edge. If none arrives, done rises after the L-th edge with term_kind=2'b11, berr=1, spurious=1 and vector=24. An answer on the L-th edge still wins.
- R8: With bm_enable=0 captured at start, a cycle never times out. It stays busy until it is answered.
- R9: done, berr and spurious last one clock. busy falls on the same clock that done rises. vector and term_kind hold their values until the next termination.
- R10: A start pulse while busy is ignored. Answers that arrive while idle, including answers after a timeout, produce no done and change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iack_start | input | 1 | One-cycle pulse: arbitration finished, cycle begins |
| win_internal | input | 1 | 1 = on-chip module won, 0 = external-request path won |
| iack_level | input | 3 | Priority level being acknowledged |
| int_ack | input | 1 | Acknowledge from the winning on-chip module |
| int_vec | input | 8 | Vector driven by the winning on-chip module |
| ext_ack | input | 1 | Acknowledge from the external device |
| ext_avec | input | 1 | Autovector request from the external device |
| ext_vec | input | 8 | Vector on the external data bus |
| cs_hit | input | 1 | Chip-select match on the acknowledge address |
| cs_avec | input | 1 | Chip-select response type: 1 = autovector, 0 = acknowledge |
| bm_enable | input | 1 | Bus monitor enable, captured at start |
| bm_limit | input | 7 | Bus monitor limit in clocks, clamped and captured at start |
| busy | output | 1 | A cycle is in progress |
| ext_cycle | output | 1 | The cycle is running on the external bus |
| done | output | 1 | One-clock termination strobe |
| term_kind | output | 2 | 00 internal vector, 01 external vector, 10 autovector, 11 bus error |
| vector | output | 8 | Vector number of the last termination |
| berr | output | 1 | Bus error strobe on timeout |
| spurious | output | 1 | Spurious-interrupt strobe on timeout |

## Verification
The checker relies on a few conditions about the inputs. Reset is low at the first edge. Every input is a settled 0 or 1 on each rising edge. The level field is never wider than three bits, so any autovector lies between 24 and 31. The bench drives all inputs on falling edges and releases each answer after a single clock. It pulses iack_start only when it means to start a cycle, or on purpose during a busy cycle to test R10. The bench sweeps every bm_limit value from 0 to 70, every level, and each kind of answer. That keeps every window and decode result within the ranges the properties assume.

// File: rtl/iack_term_pkg.sv
package iack_term_pkg;

    typedef enum logic [1:0] {
        TK_INTVEC  = 2'b00,
        TK_EXTVEC  = 2'b01,
        TK_AUTOVEC = 2'b10,
        TK_BUSERR  = 2'b11
    } term_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'b00,
        ST_WAIT_INT = 2'b01,
        ST_WAIT_EXT = 2'b10
    } ctl_state_e;

endpackage

// File: rtl/iack_bus_monitor.sv
module iack_bus_monitor #(
    parameter int LIM_W   = 7,
    parameter int LIM_MIN = 8,
    parameter int LIM_MAX = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [LIM_W-1:0] limit_i,
    input  logic             run_i,
    output logic             expired_o
);
    localparam int CNT_W = $clog2(LIM_MAX + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] lim_clamped;
    logic [31:0]      lim_ext;

    // clamp the requested window into the supported range
    always_comb begin
        lim_ext = 32'(limit_i);
        if (lim_ext < 32'(LIM_MIN)) begin
            lim_clamped = CNT_W'(LIM_MIN);
        end else if (lim_ext > 32'(LIM_MAX)) begin
            lim_clamped = CNT_W'(LIM_MAX);
        end else begin
            lim_clamped = CNT_W'(lim_ext);
        end
    end

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = lim_clamped;
        end else if (run_i && cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    // last waiting edge of the window without an answer
    assign expired_o = run_i && (cnt_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/iack_resp_decode.sv
module iack_resp_decode #(
    parameter int VEC_W     = 8,
    parameter int LVL_W     = 3,
    parameter int AVEC_BASE = 24
) (
    input  logic             wait_int_i,
    input  logic             wait_ext_i,
    input  logic             int_ack_i,
    input  logic [VEC_W-1:0] int_vec_i,
    input  logic             ext_ack_i,
    input  logic             ext_avec_i,
    input  logic [VEC_W-1:0] ext_vec_i,
    input  logic             cs_hit_i,
    input  logic             cs_avec_i,
    input  logic [LVL_W-1:0] level_i,
    output logic             hit_o,
    output logic [1:0]       kind_o,
    output logic [VEC_W-1:0] vec_o
);
    import iack_term_pkg::*;

    logic want_avec;
    logic want_ack;

    // chip-select responses count only while the cycle is on the external bus
    assign want_avec = wait_ext_i && (ext_avec_i || (cs_hit_i && cs_avec_i));
    assign want_ack  = wait_ext_i && (ext_ack_i  || (cs_hit_i && !cs_avec_i));

    always_comb begin
        hit_o  = 1'b0;
        kind_o = TK_INTVEC;
        vec_o  = '0;
        if (wait_int_i) begin
            if (int_ack_i) begin
                hit_o  = 1'b1;
                kind_o = TK_INTVEC;
                vec_o  = int_vec_i;
            end
        end else if (want_avec) begin
            hit_o  = 1'b1;
            kind_o = TK_AUTOVEC;
            vec_o  = VEC_W'(AVEC_BASE) + VEC_W'(level_i);
        end else if (want_ack) begin
            hit_o  = 1'b1;
            kind_o = TK_EXTVEC;
            vec_o  = ext_vec_i;
        end
    end

endmodule

// File: rtl/iack_term_ctrl.sv
module iack_term_ctrl #(
    parameter int VEC_W     = 8,
    parameter int LVL_W     = 3,
    parameter int LIM_W     = 7,
    parameter int LIM_MIN   = 8,
    parameter int LIM_MAX   = 64,
    parameter int AVEC_BASE = 24,
    parameter int SPUR_VEC  = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iack_start,
    input  logic             win_internal,
    input  logic [LVL_W-1:0] iack_level,
    input  logic             int_ack,
    input  logic [VEC_W-1:0] int_vec,
    input  logic             ext_ack,
    input  logic             ext_avec,
    input  logic [VEC_W-1:0] ext_vec,
    input  logic             cs_hit,
    input  logic             cs_avec,
    input  logic             bm_enable,
    input  logic [LIM_W-1:0] bm_limit,
    output logic             busy,
    output logic             ext_cycle,
    output logic             done,
    output logic [1:0]       term_kind,
    output logic [VEC_W-1:0] vector,
    output logic             berr,
    output logic             spurious
);
    import iack_term_pkg::*;

    typedef struct packed {
        ctl_state_e       state;
        logic [LVL_W-1:0] level;
        logic             bm_en;
        logic             done;
        logic             berr;
        logic             spur;
        logic [1:0]       kind;
        logic [VEC_W-1:0] vec;
    } regs_t;

    regs_t r_d, r_q;

    logic             wait_int, wait_ext, waiting;
    logic             accept_start;
    logic             resp_hit;
    logic [1:0]       resp_kind;
    logic [VEC_W-1:0] resp_vec;
    logic             bm_run, bm_expired;

    assign wait_int     = (r_q.state == ST_WAIT_INT);
    assign wait_ext     = (r_q.state == ST_WAIT_EXT);
    assign waiting      = wait_int || wait_ext;
    assign accept_start = (r_q.state == ST_IDLE) && iack_start;
    assign bm_run       = waiting && r_q.bm_en && !resp_hit;

    iack_resp_decode #(
        .VEC_W    (VEC_W),
        .LVL_W    (LVL_W),
        .AVEC_BASE(AVEC_BASE)
    ) u_decode (
        .wait_int_i (wait_int),
        .wait_ext_i (wait_ext),
        .int_ack_i  (int_ack),
        .int_vec_i  (int_vec),
        .ext_ack_i  (ext_ack),
        .ext_avec_i (ext_avec),
        .ext_vec_i  (ext_vec),
        .cs_hit_i   (cs_hit),
        .cs_avec_i  (cs_avec),
        .level_i    (r_q.level),
        .hit_o      (resp_hit),
        .kind_o     (resp_kind),
        .vec_o      (resp_vec)
    );

    iack_bus_monitor #(
        .LIM_W  (LIM_W),
        .LIM_MIN(LIM_MIN),
        .LIM_MAX(LIM_MAX)
    ) u_monitor (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (accept_start),
        .limit_i  (bm_limit),
        .run_i    (bm_run),
        .expired_o(bm_expired)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.berr = 1'b0;
        r_d.spur = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (iack_start) begin
                    r_d.state = win_internal ? ST_WAIT_INT : ST_WAIT_EXT;
                    r_d.level = iack_level;
                    r_d.bm_en = bm_enable;
                end
            end
            ST_WAIT_INT, ST_WAIT_EXT: begin
                if (resp_hit) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                    r_d.kind  = resp_kind;
                    r_d.vec   = resp_vec;
                end else if (bm_expired) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                    r_d.berr  = 1'b1;
                    r_d.spur  = 1'b1;
                    r_d.kind  = TK_BUSERR;
                    r_d.vec   = VEC_W'(SPUR_VEC);
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.level <= '0;
            r_q.bm_en <= 1'b0;
            r_q.done  <= 1'b0;
            r_q.berr  <= 1'b0;
            r_q.spur  <= 1'b0;
            r_q.kind  <= TK_INTVEC;
            r_q.vec   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = waiting;
    assign ext_cycle = wait_ext;
    assign done      = r_q.done;
    assign berr      = r_q.berr;
    assign spurious  = r_q.spur;
    assign term_kind = r_q.kind;
    assign vector    = r_q.vec;

endmodule

// File: rtl/iack_term_chk.sv
module iack_term_chk #(
    parameter int VEC_W     = 8,
    parameter int LVL_W     = 3,
    parameter int AVEC_BASE = 24,
    parameter int SPUR_VEC  = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             int_ack,
    input logic             busy,
    input logic             ext_cycle,
    input logic             done,
    input logic [1:0]       term_kind,
    input logic [VEC_W-1:0] vector,
    input logic             berr,
    input logic             spurious
);
    localparam int AVEC_TOP = AVEC_BASE + (2**LVL_W) - 1;

    // R9: controller is idle on the clock that reports a termination
    p_idle_on_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9: termination strobe lasts a single clock
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: result is held between terminations
    p_vec_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(vector) && $stable(term_kind)));

    // R10: nothing terminates unless a cycle was in progress
    p_quiet_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(busy) |-> !done);

    // R7: bus error comes with spurious flag, kind 11 and the spurious vector
    p_timeout_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        berr |-> (done && spurious && term_kind == 2'b11 && vector == VEC_W'(SPUR_VEC)));

    // R2: internal result only after an internal wait with an acknowledge
    p_int_path_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && term_kind == 2'b00) |-> ($past(int_ack) && !$past(ext_cycle) && $past(busy)));

    // R3: external vector only after an external bus cycle
    p_ext_path_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && term_kind == 2'b01) |-> $past(ext_cycle));

    // R4: autovector only from the external bus, inside the level window
    p_avec_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && term_kind == 2'b10) |->
            ($past(ext_cycle) && int'(vector) >= AVEC_BASE && int'(vector) <= AVEC_TOP));

endmodule

bind iack_term_ctrl iack_term_chk #(
    .VEC_W    (VEC_W),
    .LVL_W    (LVL_W),
    .AVEC_BASE(AVEC_BASE),
    .SPUR_VEC (SPUR_VEC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .int_ack  (int_ack),
    .busy     (busy),
    .ext_cycle(ext_cycle),
    .done     (done),
    .term_kind(term_kind),
    .vector   (vector),
    .berr     (berr),
    .spurious (spurious)
);

// File: tb/tb_iack_term_ctrl.sv
module tb_iack_term_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       iack_start = 1'b0, win_internal = 1'b0;
    logic [2:0] iack_level = '0;
    logic       int_ack = 1'b0, ext_ack = 1'b0, ext_avec = 1'b0;
    logic [7:0] int_vec = '0, ext_vec = '0;
    logic       cs_hit = 1'b0, cs_avec = 1'b0, bm_enable = 1'b0;
    logic [6:0] bm_limit = '0;
    logic       busy, ext_cycle, done, berr, spurious;
    logic [1:0] term_kind;
    logic [7:0] vector;

    int checks = 0;
    int failures = 0;

    iack_term_ctrl dut (
        .clk(clk), .rst_n(rst_n), .iack_start(iack_start), .win_internal(win_internal),
        .iack_level(iack_level), .int_ack(int_ack), .int_vec(int_vec), .ext_ack(ext_ack),
        .ext_avec(ext_avec), .ext_vec(ext_vec), .cs_hit(cs_hit), .cs_avec(cs_avec),
        .bm_enable(bm_enable), .bm_limit(bm_limit), .busy(busy), .ext_cycle(ext_cycle),
        .done(done), .term_kind(term_kind), .vector(vector), .berr(berr), .spurious(spurious)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic launch(input bit intl, input int lvl, input bit bmen, input int lim);
        @(negedge clk);
        iack_start   = 1'b1;
        win_internal = intl;
        iack_level   = 3'(lvl);
        bm_enable    = bmen;
        bm_limit     = 7'(lim);
        @(negedge clk);
        iack_start = 1'b0;
    endtask

    // mode: 0 int_ack, 1 ext_ack, 2 ext_avec, 3 cs ack, 4 cs avec, 5 ext_ack+ext_avec
    task automatic answer(input int mode, input int vec, input int k);
        for (int i = 1; i < k; i++) @(negedge clk);
        int_vec = 8'(vec);
        ext_vec = 8'(vec);
        case (mode)
            0: int_ack = 1'b1;
            1: ext_ack = 1'b1;
            2: ext_avec = 1'b1;
            3: begin cs_hit = 1'b1; cs_avec = 1'b0; end
            4: begin cs_hit = 1'b1; cs_avec = 1'b1; end
            default: begin ext_ack = 1'b1; ext_avec = 1'b1; end
        endcase
        @(negedge clk);
        int_ack = 1'b0; ext_ack = 1'b0; ext_avec = 1'b0; cs_hit = 1'b0; cs_avec = 1'b0;
    endtask

    task automatic expect_done(input string req, input int kind, input int vec);
        chk(done === 1'b1, req, int'(done), 1);
        chk(term_kind === 2'(kind), req, int'(term_kind), kind);
        chk(vector === 8'(vec), req, int'(vector), vec);
        chk(busy === 1'b0, req, int'(busy), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n, expl;
        repeat (3) @(negedge clk);
        // R1 during and after reset
        chk({busy, ext_cycle, done, berr, spurious} === 5'b0, "R1", int'({busy, ext_cycle, done, berr, spurious}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, ext_cycle, done, berr, spurious} === 5'b0 && vector === 8'd0 && term_kind === 2'd0,
            "R1", int'(vector), 0);

        // R2 internal vectors at several latencies
        for (int v = 0; v < 8; v++) begin
            launch(1'b1, v, 1'b1, 64);
            chk(busy === 1'b1 && ext_cycle === 1'b0, "R2", int'(ext_cycle), 0);
            answer(0, 8'h40 + v * 23, v + 1);
            expect_done("R2", 0, 8'h40 + v * 23);
        end

        // R6 external-side answers ignored during internal wait
        launch(1'b1, 5, 1'b1, 64);
        answer(1, 8'h11, 1);
        answer(2, 8'h12, 1);
        answer(4, 8'h13, 1);
        answer(3, 8'h14, 1);
        chk(done === 1'b0 && busy === 1'b1, "R6", int'(done), 0);
        answer(0, 8'h99, 1);
        expect_done("R6", 0, 8'h99);

        // R3 external acknowledge
        for (int v = 0; v < 6; v++) begin
            launch(1'b0, 2, 1'b1, 64);
            chk(ext_cycle === 1'b1 && busy === 1'b1, "R3", int'(ext_cycle), 1);
            answer(1, 8'hC0 + v * 7, v + 2);
            expect_done("R3", 1, 8'hC0 + v * 7);
        end

        // R4 autovector for every level, and priority over ack
        for (int l = 0; l < 8; l++) begin
            launch(1'b0, l, 1'b1, 20);
            answer(2, 8'h55, 2);
            expect_done("R4", 2, 24 + l);
            launch(1'b0, l, 1'b1, 20);
            answer(5, 8'h55, 1);
            expect_done("R4", 2, 24 + l);
        end

        // R5 chip-select responses
        for (int l = 0; l < 8; l++) begin
            launch(1'b0, l, 1'b1, 30);
            answer(4, 8'h77, 3);
            expect_done("R5", 2, 24 + l);
            launch(1'b0, l, 1'b1, 30);
            answer(3, 8'h80 + l, 3);
            expect_done("R5", 1, 8'h80 + l);
        end

        // R7 window sweep with clamping, both paths
        for (int lim = 0; lim <= 70; lim++) begin
            expl = (lim < 8) ? 8 : ((lim > 64) ? 64 : lim);
            launch(lim[0], 3, 1'b1, lim);
            n = 0;
            do begin @(negedge clk); n++; end while (!done && n < 100);
            chk(n == expl, "R7", n, expl);
            chk(berr === 1'b1 && spurious === 1'b1, "R7", int'({berr, spurious}), 3);
            chk(term_kind === 2'd3 && vector === 8'd24, "R7", int'(vector), 24);
            @(negedge clk);
            chk(done === 1'b0 && berr === 1'b0 && spurious === 1'b0, "R9", int'(done), 0);
        end

        // R7 boundary: answer on the last edge of the window wins
        launch(1'b0, 1, 1'b1, 8);
        answer(1, 8'hE1, 8);
        expect_done("R7", 1, 8'hE1);
        chk(berr === 1'b0, "R7", int'(berr), 0);

        // R10 answer one edge too late: timeout, then late answer ignored
        launch(1'b0, 1, 1'b1, 8);
        for (int i = 0; i < 8; i++) @(negedge clk);
        chk(done === 1'b1 && berr === 1'b1, "R7", int'(berr), 1);
        answer(1, 8'hE2, 1);
        chk(done === 1'b0 && vector === 8'd24 && term_kind === 2'd3, "R10", int'(vector), 24);
        answer(2, 8'hE3, 1);
        answer(0, 8'hE4, 1);
        chk(done === 1'b0 && vector === 8'd24 && busy === 1'b0, "R10", int'(vector), 24);

        // R8 monitor disabled: no timeout
        launch(1'b0, 6, 1'b0, 8);
        n = 0;
        for (int i = 0; i < 150; i++) begin @(negedge clk); if (done) n++; end
        chk(n == 0 && busy === 1'b1, "R8", n, 0);
        answer(2, 0, 1);
        expect_done("R8", 2, 30);

        // R9 hold after termination
        @(negedge clk);
        chk(done === 1'b0 && vector === 8'd30 && term_kind === 2'd2, "R9", int'(vector), 30);

        // R10 start while busy is ignored
        launch(1'b0, 4, 1'b1, 64);
        launch(1'b1, 0, 1'b1, 8);
        chk(ext_cycle === 1'b1 && busy === 1'b1, "R10", int'(ext_cycle), 1);
        answer(0, 8'h21, 1);
        chk(done === 1'b0 && busy === 1'b1, "R10", int'(done), 0);
        answer(1, 8'h3C, 1);
        expect_done("R10", 1, 8'h3C);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule